// File: doc/BRIEF.md
# Multi-Mode Bidirectional Shift Register

This block is a WIDTH-bit register, four bits by default. A 4-bit mode code chooses what happens on each rising clock edge. The register can hold its contents, take a new word from a parallel data bus, or move its contents one place left or right.

Each shift direction has its own choice of fill for the vacated end bit:

- a dedicated serial input,
- a constant zero,
- the bit that just left the register (rotate),
- the complement of that bit (Johnson, also called switch-tail),
- for arithmetic right shifts, a copy of the current most significant bit.

A registered shift-out bit records which bit left the register on the most recent shift. The block is meant to sit inside a datapath. A controller drives one mode code per cycle, and every change takes effect on the clock edge only. An active-low asynchronous reset clears all state.

Top module: `bidir_shift_reg`

## Requirements
- R1: While rst_n is low, both data_o and shift_out_o are 0, whether or not the clock is running.
- R2: Mode 4'b0000 holds the state, and so do the unused codes 4'b1100 through 4'b1111. data_o and shift_out_o both keep their values.
- R3: Mode 4'b0001 copies par_i into data_o on the edge and leaves shift_out_o unchanged.
- R4: Mode 4'b0010 shifts toward the MSB and fills bit 0 with ser_left_i.
- R5: Mode 4'b0011 shifts toward the LSB and fills bit WIDTH-1 with ser_right_i.
- R6: Mode 4'b0100 shifts left and fills bit 0 with zero, so 0110 becomes 1100. Mode 4'b0101 shifts right and fills the MSB with zero, so 0110 becomes 0011.
- R7: Mode 4'b0110 rotates left and mode 4'b0111 rotates right. For example, 1001 becomes 0011 when rotated left and 1100 when rotated right.
- R8: Mode 4'b1000 (Johnson left) and mode 4'b1001 (Johnson right) fill the vacated bit with the inverse of the bit that left. For example, 1001 becomes 0010 going left and 0100 going right.
- R9: Mode 4'b1010 is an arithmetic right shift: the MSB keeps its value. For example, 1011 becomes 1101 and 0110 becomes 0011.
- R10: Mode 4'b1011 is an arithmetic left shift and gives the same result as mode 4'b0100.
- R11: On every shift code, shift_out_o takes the departing bit. That is the old bit WIDTH-1 for left shifts (codes 0010, 0100, 0110, 1000, 1011) and the old bit 0 for right shifts (codes 0011, 0101, 0111, 1001, 1010).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Operation code for this cycle |
| par_i | input | WIDTH | Parallel load word |
| ser_left_i | input | 1 | Fill bit for serial left shift |
| ser_right_i | input | 1 | Fill bit for serial right shift |
| data_o | output | WIDTH | Register contents |
| shift_out_o | output | 1 | Bit that left on the latest shift |

## Verification
The hardest case to reach from the ports is one where shift_out_o holds a bit that differs from the one a fresh shift would give. Only in that case does a load or hold cycle prove that shift_out_o is really left untouched.

To get there, the bench sets up a known pattern, shifts out a chosen bit, and then loads a word whose departing bits have the opposite value. It then holds on both the defined hold code and the unused codes. A sweep then starts every mode from 0101, with parallel data 0011, ser_left_i high and ser_right_i low. A long random sequence compared cycle by cycle covers mixed orderings of modes.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    localparam int unsigned MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        OP_HOLD    = 4'd0,
        OP_LOAD    = 4'd1,
        OP_SER_L   = 4'd2,
        OP_SER_R   = 4'd3,
        OP_ZERO_L  = 4'd4,
        OP_ZERO_R  = 4'd5,
        OP_ROT_L   = 4'd6,
        OP_ROT_R   = 4'd7,
        OP_JOHN_L  = 4'd8,
        OP_JOHN_R  = 4'd9,
        OP_ARITH_R = 4'd10,
        OP_ARITH_L = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_LEFT,
        ACT_RIGHT
    } act_e;

    typedef enum logic [2:0] {
        FILL_ZERO,
        FILL_SER,
        FILL_WRAP,
        FILL_INV,
        FILL_SIGN
    } fill_e;

    typedef struct packed {
        act_e  act;
        fill_e fill;
    } ctrl_t;

endpackage

// File: rtl/shreg_decode.sv
module shreg_decode
    import shreg_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output ctrl_t             ctrl_o
);

    always_comb begin
        ctrl_o.act  = ACT_HOLD;
        ctrl_o.fill = FILL_ZERO;
        case (op_e'(mode_i))
            OP_LOAD:    ctrl_o.act = ACT_LOAD;
            OP_SER_L:   begin ctrl_o.act = ACT_LEFT;  ctrl_o.fill = FILL_SER;  end
            OP_SER_R:   begin ctrl_o.act = ACT_RIGHT; ctrl_o.fill = FILL_SER;  end
            OP_ZERO_L:  ctrl_o.act = ACT_LEFT;
            OP_ZERO_R:  ctrl_o.act = ACT_RIGHT;
            OP_ROT_L:   begin ctrl_o.act = ACT_LEFT;  ctrl_o.fill = FILL_WRAP; end
            OP_ROT_R:   begin ctrl_o.act = ACT_RIGHT; ctrl_o.fill = FILL_WRAP; end
            OP_JOHN_L:  begin ctrl_o.act = ACT_LEFT;  ctrl_o.fill = FILL_INV;  end
            OP_JOHN_R:  begin ctrl_o.act = ACT_RIGHT; ctrl_o.fill = FILL_INV;  end
            OP_ARITH_R: begin ctrl_o.act = ACT_RIGHT; ctrl_o.fill = FILL_SIGN; end
            OP_ARITH_L: ctrl_o.act = ACT_LEFT;
            default:    ctrl_o.act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/shreg_fill.sv
module shreg_fill
    import shreg_pkg::*;
(
    input  ctrl_t ctrl_i,
    input  logic  cur_msb_i,
    input  logic  cur_lsb_i,
    input  logic  ser_left_i,
    input  logic  ser_right_i,
    output logic  fill_o,
    output logic  depart_o
);

    always_comb begin
        depart_o = (ctrl_i.act == ACT_LEFT) ? cur_msb_i : cur_lsb_i;
        case (ctrl_i.fill)
            FILL_SER:  fill_o = (ctrl_i.act == ACT_LEFT) ? ser_left_i : ser_right_i;
            FILL_WRAP: fill_o = depart_o;
            FILL_INV:  fill_o = ~depart_o;
            FILL_SIGN: fill_o = cur_msb_i;
            default:   fill_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/shreg_shift_net.sv
module shreg_shift_net #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             fill_i,
    output logic [WIDTH-1:0] left_o,
    output logic [WIDTH-1:0] right_o
);

    localparam int unsigned TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low
            assign left_o[i] = fill_i;
        end else begin : g_low_mid
            assign left_o[i] = cur_i[i-1];
        end
        if (i == TOP) begin : g_high
            assign right_o[i] = fill_i;
        end else begin : g_high_mid
            assign right_o[i] = cur_i[i+1];
        end
    end

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
    import shreg_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MODE_W-1:0]     mode_i,
    input  logic [WIDTH-1:0]      par_i,
    input  logic                  ser_left_i,
    input  logic                  ser_right_i,
    output logic [WIDTH-1:0]      data_o,
    output logic                  shift_out_o
);

    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             shout;
    } state_t;

    state_t           st_d, st_q;
    ctrl_t            ctrl;
    logic             fill_bit;
    logic             depart_bit;
    logic [WIDTH-1:0] shl_word;
    logic [WIDTH-1:0] shr_word;

    shreg_decode u_decode (
        .mode_i (mode_i),
        .ctrl_o (ctrl)
    );

    shreg_fill u_fill (
        .ctrl_i      (ctrl),
        .cur_msb_i   (st_q.data[MSB]),
        .cur_lsb_i   (st_q.data[0]),
        .ser_left_i  (ser_left_i),
        .ser_right_i (ser_right_i),
        .fill_o      (fill_bit),
        .depart_o    (depart_bit)
    );

    shreg_shift_net #(.WIDTH(WIDTH)) u_net (
        .cur_i   (st_q.data),
        .fill_i  (fill_bit),
        .left_o  (shl_word),
        .right_o (shr_word)
    );

    always_comb begin
        st_d = st_q;
        case (ctrl.act)
            ACT_LOAD:  st_d.data = par_i;
            ACT_LEFT:  begin st_d.data = shl_word; st_d.shout = depart_bit; end
            ACT_RIGHT: begin st_d.data = shr_word; st_d.shout = depart_bit; end
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o      = st_q.data;
    assign shift_out_o = st_q.shout;

    logic is_hold, is_left, is_right;
    assign is_hold  = (mode_i == OP_HOLD) || (mode_i >= 4'd12);
    assign is_left  = (mode_i == OP_SER_L) || (mode_i == OP_ZERO_L) || (mode_i == OP_ROT_L)
                   || (mode_i == OP_JOHN_L) || (mode_i == OP_ARITH_L);
    assign is_right = (mode_i == OP_SER_R) || (mode_i == OP_ZERO_R) || (mode_i == OP_ROT_R)
                   || (mode_i == OP_JOHN_R) || (mode_i == OP_ARITH_R);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        is_hold |=> $stable(data_o) && $stable(shift_out_o)); // R2
    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OP_LOAD) |=> data_o == $past(par_i)); // R3
    AST_LOAD_KEEP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OP_LOAD) |=> $stable(shift_out_o)); // R3
    AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OP_ROT_L || mode_i == OP_ROT_R)
        |=> $countones(data_o) == $countones($past(data_o))); // R7
    AST_ASR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OP_ARITH_R) |=> data_o[MSB] == $past(data_o[MSB])); // R9
    AST_LEFT_DEPART: assert property (@(posedge clk) disable iff (!rst_n)
        is_left |=> shift_out_o == $past(data_o[MSB])); // R11
    AST_RIGHT_DEPART: assert property (@(posedge clk) disable iff (!rst_n)
        is_right |=> shift_out_o == $past(data_o[0])); // R11

endmodule

// File: tb/bidir_shift_reg_bench.sv
`timescale 1ns/1ps
module bidir_shift_reg_bench;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   mode_i = '0;
    logic [W-1:0] par_i = '0;
    logic         ser_left_i = 1'b0;
    logic         ser_right_i = 1'b0;
    logic [W-1:0] data_o;
    logic         shift_out_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int exp_val = 0;
    int exp_out = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bidir_shift_reg #(.WIDTH(W)) u_bidir_shift_reg (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .par_i(par_i),
        .ser_left_i(ser_left_i), .ser_right_i(ser_right_i),
        .data_o(data_o), .shift_out_o(shift_out_o)
    );

    function automatic string tag_of(int m);
        case (m)
            1:      return "R3";
            2:      return "R4";
            3:      return "R5";
            4, 5:   return "R6";
            6, 7:   return "R7";
            8, 9:   return "R8";
            10:     return "R9";
            11:     return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string tag, int act_v, int exp_v, int act_o, int exp_o);
        checks++;
        if (act_v != exp_v || act_o != exp_o) begin
            failures++;
            $display("FAIL %s data=%0h exp=%0h shout=%0d exp=%0d", tag, act_v, exp_v, act_o, exp_o);
        end
    endtask

    task automatic model(int m, int p, int l, int r);
        int hi = (exp_val >> (W - 1)) & 1;
        int lo = exp_val & 1;
        case (m)
            1:  exp_val = p;
            2:  begin exp_val = ((exp_val * 2) + l) & MASK;       exp_out = hi; end
            3:  begin exp_val = (exp_val / 2) + r * (1 << (W-1)); exp_out = lo; end
            4, 11: begin exp_val = (exp_val * 2) & MASK;          exp_out = hi; end
            5:  begin exp_val = exp_val / 2;                      exp_out = lo; end
            6:  begin exp_val = ((exp_val * 2) + hi) & MASK;      exp_out = hi; end
            7:  begin exp_val = (exp_val / 2) + lo * (1 << (W-1)); exp_out = lo; end
            8:  begin exp_val = ((exp_val * 2) + (1 - hi)) & MASK; exp_out = hi; end
            9:  begin exp_val = (exp_val / 2) + (1 - lo) * (1 << (W-1)); exp_out = lo; end
            10: begin exp_val = (exp_val / 2) + hi * (1 << (W-1)); exp_out = lo; end
            default: ;
        endcase
    endtask

    task automatic step(int m, int p, int l, int r);
        mode_i = 4'(m); par_i = W'(p); ser_left_i = 1'(l); ser_right_i = 1'(r);
        model(m, p, l, r);
        @(posedge clk);
        @(negedge clk);
        check(tag_of(m), int'(data_o), exp_val, int'(shift_out_o), exp_out);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(data_o), 0, int'(shift_out_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // literal corner values from the requirements
        step(1, 4'b0110, 0, 0); step(4, 0, 0, 0);
        check("R6", int'(data_o), 4'b1100, int'(shift_out_o), 0);
        step(1, 4'b0110, 0, 0); step(5, 0, 0, 0);
        check("R6", int'(data_o), 4'b0011, int'(shift_out_o), 0);
        step(1, 4'b1001, 0, 0); step(6, 0, 0, 0);
        check("R7", int'(data_o), 4'b0011, int'(shift_out_o), 1);
        step(1, 4'b1001, 0, 0); step(7, 0, 0, 0);
        check("R7", int'(data_o), 4'b1100, int'(shift_out_o), 1);
        step(1, 4'b1001, 0, 0); step(8, 0, 0, 0);
        check("R8", int'(data_o), 4'b0010, int'(shift_out_o), 1);
        step(1, 4'b1001, 0, 0); step(9, 0, 0, 0);
        check("R8", int'(data_o), 4'b0100, int'(shift_out_o), 1);
        step(1, 4'b1011, 0, 0); step(10, 0, 0, 0);
        check("R9", int'(data_o), 4'b1101, int'(shift_out_o), 1);
        step(1, 4'b0110, 0, 0); step(10, 0, 0, 0);
        check("R9", int'(data_o), 4'b0011, int'(shift_out_o), 0);
        step(1, 4'b0111, 0, 0); step(11, 0, 0, 0);
        check("R10", int'(data_o), 4'b1110, int'(shift_out_o), 0);
        step(1, 4'b0101, 0, 0); step(2, 0, 1, 0);
        check("R4", int'(data_o), 4'b1011, int'(shift_out_o), 0);
        step(1, 4'b1010, 0, 0); step(3, 0, 0, 1);
        check("R5", int'(data_o), 4'b1101, int'(shift_out_o), 0);

        // shout = 1, then load/hold must keep it (R3, R2, R11)
        step(1, 4'b1000, 0, 0); step(4, 0, 0, 0);
        check("R11", int'(data_o), 0, int'(shift_out_o), 1);
        step(1, 4'b0110, 0, 0);
        check("R3", int'(data_o), 4'b0110, int'(shift_out_o), 1);
        for (int c = 0; c < 16; c++) begin
            if (c == 0 || c >= 12) step(c, 4'b1001, 1, 1);
        end
        check("R2", int'(data_o), 4'b0110, int'(shift_out_o), 1);

        // every mode from 0101, par 0011, left serial 1, right serial 0
        for (int m = 0; m < 16; m++) begin
            step(1, 4'b0101, 0, 0);
            step(m, 4'b0011, 1, 0);
        end

        // random mixed sequence
        for (int k = 0; k < 400; k++) begin
            step(int'($urandom_range(15, 0)), int'($urandom_range(MASK, 0)),
                 int'($urandom_range(1, 0)), int'($urandom_range(1, 0)));
        end

        // asynchronous reset mid-run without a clock edge
        step(1, 4'b1111, 0, 0); step(4, 0, 0, 0);
        #1 rst_n = 1'b0;
        #0.5;
        check("R1", int'(data_o), 0, int'(shift_out_o), 0);
        exp_val = 0; exp_out = 0;
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0);
        finish_run();
    end

endmodule